// File: doc/BRIEF.md
# Microcode ALU With Carry Flag

This block is the execute stage of a small microcode engine. It is fed two 16-bit operands, a 5-bit operation code, two 4-bit immediates that only the extended operations read (a shift count and a field-size count), and the present carry flag. From these it computes a result word and a proposed carry value, together with a strobe that tells the flag register whether to take that value. Operand fetch, addressing, the register file and instruction decoding sit outside the block.

All outputs are registered, so a result appears one clock after its inputs. The add and subtract codes let the microcode choose two things independently: whether the incoming carry feeds the sum, and whether the new carry is written back. Multi-word arithmetic can therefore run without disturbing the flag when that is not wanted. There is no state machine. The only state is the output register, which is loaded every cycle that reset is inactive.

Top module: `ucode_alu`

## Requirements
- R1: While `rst_n` is low, `res_o`, `cy_o` and `cy_we_o` are 0. Out of reset, the outputs show the function of the inputs that were present at the previous rising clock edge.
- R2: Codes 0 to 3 add. `res_o` is the low 16 bits of A + B + k, where k is `cy_i` for codes 2 and 3 and 0 for codes 0 and 1. The carry-out is bit 16 of that sum.
- R3: Codes 4 to 7 subtract. `res_o` is the low 16 bits of A + ~B + k, where k is `cy_i` for codes 6 and 7 and 1 for codes 4 and 5. The carry-out is bit 16, so 1 means no borrow.
- R4: `cy_we_o` is 1 only for codes 1, 3, 5 and 7, and `cy_o` then carries the carry-out. For every other code, `cy_we_o` is 0 and `cy_o` equals `cy_i`.
- R5: Code 8 gives A|B, code 9 gives A&B, and code 10 gives A^B.
- R6: Code 11 gives A & ~B (bit clear).
- R7: Code 12 shifts A left, code 13 shifts A right logically, and code 14 shifts A right arithmetically. Each shifts by the low 4 bits of B.
- R8: Code 15 rotates A left and code 16 rotates A right, each by the low 4 bits of B. An amount of 0 returns A.
- R9: Code 17 shifts the 32-bit value {A,B} right by `xsh_i` and keeps the low 16 bits ANDed with a mask of `xmsk_i`+1 low ones.
- R10: Code 18 forms M = (`xmsk_i`+1 low ones) << `xsh_i`, truncated to 16 bits. The result is ((A << `xsh_i`) & M) | (B & ~M).
- R11: Codes 19 to 31 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code |
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B (also the shift amount for codes 12 to 16) |
| xsh_i | input | 4 | Shift count for codes 17 and 18 |
| xmsk_i | input | 4 | Field size minus one for codes 17 and 18 |
| cy_i | input | 1 | Current carry flag |
| res_o | output | 16 | Registered result |
| cy_o | output | 1 | Registered next carry |
| cy_we_o | output | 1 | Registered carry write enable |

## Verification
The bench builds the block with its default width of 16, so the shift and field parameters are 4 bits wide. All 256 pairs of shift count and field size are then swept for both extended operations, and all 16 shift amounts are swept for every shift and rotate. Every one of the 32 opcodes is crossed with eight edge operands (zero, one, the sign boundaries, all ones) on both carry values. Pseudo-random operands follow, so the carry and borrow paths are checked far beyond the edge values.

// File: rtl/ucode_alu_pkg.sv
package ucode_alu_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD      = 5'd0,
        OP_ADD_U    = 5'd1,
        OP_ADD_C    = 5'd2,
        OP_ADD_CU   = 5'd3,
        OP_SUB      = 5'd4,
        OP_SUB_U    = 5'd5,
        OP_SUB_C    = 5'd6,
        OP_SUB_CU   = 5'd7,
        OP_OR       = 5'd8,
        OP_AND      = 5'd9,
        OP_XOR      = 5'd10,
        OP_CLR      = 5'd11,
        OP_SHL      = 5'd12,
        OP_SHR      = 5'd13,
        OP_SAR      = 5'd14,
        OP_ROL      = 5'd15,
        OP_ROR      = 5'd16,
        OP_XSHR     = 5'd17,
        OP_MERGE    = 5'd18
    } op_e;
endpackage

// File: rtl/ucode_alu_arith.sv
module ucode_alu_arith #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    input  logic             use_cin,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] b_eff;
    logic             k;
    logic [WIDTH:0]   total;

    always_comb begin
        b_eff = sub ? ~b : b;
        k     = use_cin ? cin : sub;
        total = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, k};
        sum   = total[WIDTH-1:0];
        cout  = total[WIDTH];
    end
endmodule

// File: rtl/ucode_alu_logic.sv
module ucode_alu_logic #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y_or,
    output logic [WIDTH-1:0] y_and,
    output logic [WIDTH-1:0] y_xor,
    output logic [WIDTH-1:0] y_clr
);
    always_comb begin
        y_or  = a | b;
        y_and = a & b;
        y_xor = a ^ b;
        y_clr = a & ~b;
    end
endmodule

// File: rtl/ucode_alu_shift.sv
module ucode_alu_shift #(
    parameter int WIDTH = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [SHW-1:0]   amt,
    input  logic [SHW-1:0]   xsh,
    input  logic [SHW-1:0]   xmsk,
    output logic [WIDTH-1:0] y_shl,
    output logic [WIDTH-1:0] y_shr,
    output logic [WIDTH-1:0] y_sar,
    output logic [WIDTH-1:0] y_rol,
    output logic [WIDTH-1:0] y_ror,
    output logic [WIDTH-1:0] y_xshr,
    output logic [WIDTH-1:0] y_merge
);
    logic [WIDTH-1:0]   field;
    logic [WIDTH-1:0]   place;
    logic [2*WIDTH-1:0] dbl_l;
    logic [2*WIDTH-1:0] dbl_r;
    logic [2*WIDTH-1:0] pair;

    // field mask: bit i set when i <= xmsk
    for (genvar i = 0; i < WIDTH; i++) begin : g_field
        assign field[i] = (SHW'(i) <= xmsk);
    end

    always_comb begin
        y_shl   = a << amt;
        y_shr   = a >> amt;
        y_sar   = WIDTH'($signed(a) >>> amt);
        dbl_l   = {a, a} << amt;
        dbl_r   = {a, a} >> amt;
        y_rol   = dbl_l[2*WIDTH-1:WIDTH];
        y_ror   = dbl_r[WIDTH-1:0];
        pair    = {a, b} >> xsh;
        y_xshr  = pair[WIDTH-1:0] & field;
        place   = field << xsh;
        y_merge = ((a << xsh) & place) | (b & ~place);
    end
endmodule

// File: rtl/ucode_alu.sv
module ucode_alu
    import ucode_alu_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [SHW-1:0]   xsh_i,
    input  logic [SHW-1:0]   xmsk_i,
    input  logic             cy_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cy_o,
    output logic             cy_we_o
);
    op_e              op;
    logic             is_arith;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic [WIDTH-1:0] y_or, y_and, y_xor, y_clr;
    logic [WIDTH-1:0] y_shl, y_shr, y_sar, y_rol, y_ror, y_xshr, y_merge;
    logic [WIDTH-1:0] res_d;
    logic             cy_d;
    logic             we_d;

    assign op       = op_e'(op_i);
    assign is_arith = (op_i[OP_W-1:3] == '0);

    ucode_alu_arith #(.WIDTH(WIDTH)) i_arith (
        .a(opa_i), .b(opb_i), .sub(op_i[2]), .use_cin(op_i[1]), .cin(cy_i),
        .sum(sum), .cout(cout)
    );

    ucode_alu_logic #(.WIDTH(WIDTH)) i_logic (
        .a(opa_i), .b(opb_i),
        .y_or(y_or), .y_and(y_and), .y_xor(y_xor), .y_clr(y_clr)
    );

    ucode_alu_shift #(.WIDTH(WIDTH)) i_shift (
        .a(opa_i), .b(opb_i), .amt(opb_i[SHW-1:0]), .xsh(xsh_i), .xmsk(xmsk_i),
        .y_shl(y_shl), .y_shr(y_shr), .y_sar(y_sar), .y_rol(y_rol),
        .y_ror(y_ror), .y_xshr(y_xshr), .y_merge(y_merge)
    );

    // next-value selection
    always_comb begin
        we_d = is_arith & op_i[0];
        cy_d = we_d ? cout : cy_i;
        unique case (op)
            OP_ADD, OP_ADD_U, OP_ADD_C, OP_ADD_CU,
            OP_SUB, OP_SUB_U, OP_SUB_C, OP_SUB_CU: res_d = sum;
            OP_OR:    res_d = y_or;
            OP_AND:   res_d = y_and;
            OP_XOR:   res_d = y_xor;
            OP_CLR:   res_d = y_clr;
            OP_SHL:   res_d = y_shl;
            OP_SHR:   res_d = y_shr;
            OP_SAR:   res_d = y_sar;
            OP_ROL:   res_d = y_rol;
            OP_ROR:   res_d = y_ror;
            OP_XSHR:  res_d = y_xshr;
            OP_MERGE: res_d = y_merge;
            default:  res_d = '0;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            cy_o    <= 1'b0;
            cy_we_o <= 1'b0;
        end else begin
            res_o   <= res_d;
            cy_o    <= cy_d;
            cy_we_o <= we_d;
        end
    end

    assert_carry_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_i[OP_W-1:3] == '0 && op_i[0]) |=> (!cy_we_o && cy_o == $past(cy_i)));

    assert_sub_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd5 && opa_i == opb_i) |=> (res_o == '0 && cy_o && cy_we_o));

    assert_clear_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd11) |=> ((res_o & $past(opb_i)) == '0));

    assert_rotate_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd15 && opb_i[SHW-1:0] == '0) |=> (res_o == $past(opa_i)));

    assert_field_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd17) |=> ((res_o >> (32'($past(xmsk_i)) + 32'd1)) == '0));

    assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 5'd18) |=> (res_o == '0));
endmodule

// File: tb/test_ucode_alu.sv
module test_ucode_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [15:0] opa_i = '0, opb_i = '0;
    logic [3:0]  xsh_i = '0, xmsk_i = '0;
    logic        cy_i = 1'b0;
    logic [15:0] res_o;
    logic        cy_o, cy_we_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ucode_alu i_ucode_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .xsh_i(xsh_i), .xmsk_i(xmsk_i), .cy_i(cy_i),
        .res_o(res_o), .cy_o(cy_o), .cy_we_o(cy_we_o)
    );

    function automatic string tag(input logic [4:0] op);
        if (op <= 5'd3)       return "R2/R4";
        else if (op <= 5'd7)  return "R3/R4";
        else if (op <= 5'd10) return "R5";
        else if (op == 5'd11) return "R6";
        else if (op <= 5'd14) return "R7";
        else if (op <= 5'd16) return "R8";
        else if (op == 5'd17) return "R9";
        else if (op == 5'd18) return "R10";
        else                  return "R11";
    endfunction

    // expected {we, carry, result} from the requirement text
    function automatic logic [17:0] model(input logic [4:0] op, input logic [15:0] a, b,
                                          input logic [3:0] s, m, input logic c);
        logic [31:0] r, t, fm, pm;
        logic        we, cy;
        int n;
        n  = int'(b[3:0]);
        r  = 0; we = 0; cy = c;
        fm = (32'd1 << (m + 1)) - 32'd1;
        if (op <= 5'd7) begin
            t  = {16'd0, a} + (op[2] ? {16'd0, ~b} : {16'd0, b})
               + (op[1] ? {31'd0, c} : {31'd0, op[2]});
            r  = t;
            we = op[0];
            if (we) cy = t[16];
        end else begin
            case (op)
                5'd8:  r = a | b;
                5'd9:  r = a & b;
                5'd10: r = a ^ b;
                5'd11: r = a & ~b;
                5'd12: r = {16'd0, a} << n;
                5'd13: r = {16'd0, a} >> n;
                5'd14: r = ({16'd0, a} >> n) | (a[15] ? ~(32'hFFFF >> n) : 32'd0);
                5'd15: r = ({16'd0, a} << n) | ({16'd0, a} >> (16 - n));
                5'd16: r = ({16'd0, a} >> n) | ({16'd0, a} << (16 - n));
                5'd17: r = ({a, b} >> s) & fm;
                5'd18: begin
                    pm = (fm << s) & 32'hFFFF;
                    r  = (({16'd0, a} << s) & pm) | ({16'd0, b} & ~pm);
                end
                default: r = 0;
            endcase
        end
        return {we, cy, r[15:0]};
    endfunction

    task automatic run(input logic [4:0] op, input logic [15:0] a, b,
                       input logic [3:0] s, m, input logic c);
        logic [17:0] e;
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; xsh_i = s; xmsk_i = m; cy_i = c;
        e = model(op, a, b, s, m, c);
        @(posedge clk); #1;
        checks++;
        if ({cy_we_o, cy_o, res_o} !== e) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h s=%0d m=%0d c=%0d actual we=%b cy=%b res=%h expected we=%b cy=%b res=%h",
                     tag(op), op, a, b, s, m, c, cy_we_o, cy_o, res_o, e[17], e[16], e[15:0]);
        end
    endtask

    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                              16'h8000, 16'hFFFE, 16'hFFFF, 16'h5A3C};

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        // R1: reset state, with busy inputs
        op_i = 5'd3; opa_i = 16'hFFFF; opb_i = 16'h0001; cy_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (res_o !== 16'd0 || cy_o !== 1'b0 || cy_we_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 actual res=%h cy=%b we=%b expected 0 0 0", res_o, cy_o, cy_we_o);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1 latency and R2..R11: every opcode crossed with edge operands
        for (int op = 0; op < 32; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int c = 0; c < 2; c++)
                        run(5'(op), vals[i], vals[j], 4'(i + j), 4'(15 - i), 1'(c));
        // R7, R8: every shift amount
        for (int op = 12; op <= 16; op++)
            for (int i = 0; i < 8; i++)
                for (int n = 0; n < 16; n++)
                    run(5'(op), vals[i], 16'hA5F0 | 16'(n), 4'd0, 4'd0, 1'b0);
        // R9, R10: every shift count and field size
        for (int op = 17; op <= 18; op++)
            for (int s = 0; s < 16; s++)
                for (int m = 0; m < 16; m++) begin
                    run(5'(op), 16'hC3A5, 16'h1E87, 4'(s), 4'(m), 1'b0);
                    run(5'(op), 16'hFFFF, 16'h0000, 4'(s), 4'(m), 1'b1);
                end
        // R2, R3, R4 and the rest: pseudo-random operands
        lf = 32'hACE1_2468;
        for (int k = 0; k < 3000; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = lf * 32'd1664525 + 32'd1013904223;
            run(5'(lf[31:27] % 5'd20), lf[15:0], lf[26:11], lf[3:0], lf[7:4], lf[9]);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule